// File: doc/BRIEF.md
# Display Address Wraparound Adder

This block turns the character address and row lines produced by a video address counter into a byte address for a 32K video RAM. In the bitmap layouts, the character address and the row lines form one linear byte address. The screen scrolls in hardware: software advances the display start address by one text line of bytes and copies no memory. As a result, the linear address can run past the 32K top of RAM. When it does, the block folds the address back into the display region. It does this by adding a small constant to the four high-order address bits. A two-bit geometry code selects the constant, and the code also sets the size of the display region.

The top bit of the character address marks the teletext layout. In that layout the block uses a separate compact mapping into the highest 1K of RAM, and the row lines play no part. The block is purely combinational, so `ram_addr` follows its inputs in the same cycle. Programming the start address and generating sync are done elsewhere.

Top module: `vid_addr_wrap`

## Requirements
- R1: With `char_addr[13]`=0 and `char_addr[12]`=0, `ram_addr` = `char_addr[11:0]`*8 + `row_line`, unchanged.
- R2: With `char_addr[13]`=0 and `char_addr[12]`=1, the linear address L = `char_addr[12:0]`*8 + `row_line` (16 bits, at least 32768) is folded to `ram_addr` = (L - S) mod 32768, where S is the region size in bytes. Only bits [14:11] differ from L; bits [10:0] are passed through.
- R3: Region size by `geom_sel`: 0 gives 20K (added constant 6), 1 gives 16K (constant 8), 2 gives 10K (constant 11), 3 gives 8K (constant 12). Each constant is (16 - S/2K) mod 16, added to address bits [14:11].
- R4: With `char_addr[13]`=1, `ram_addr` = 0x7C00 + `char_addr[9:0]`, which lies in the top 1K of RAM.
- R5: In the teletext layout, `row_line`, `geom_sel` and `char_addr[12:10]` have no effect on `ram_addr`.
- R6: For any folded linear address L below 32768 + S, `ram_addr` lies in the region [32768 - S, 32767].
- R7: The output is combinational and valid in the same cycle as its inputs, with no clock or state.
- R8: Across the wrap, stepping L from 32767 to 32768 moves `ram_addr` from 32767 to 32768 - S, the bottom of the region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| char_addr | input | 14 | Character address from the video counter; bit 13 selects the teletext layout |
| geom_sel | input | 2 | Display geometry code that selects the region size and the fold constant |
| row_line | input | 3 | Scan row within a character cell (bitmap layouts only) |
| ram_addr | output | 15 | Byte address into the 32K video RAM |

## Verification
The block holds no state, so any fault shows on `ram_addr` in the same cycle as the input that exposes it. A wrong fold constant or a broken carry in the high-bit adder shows only when the linear address crosses 32K. The error then appears in bits [14:11] for that geometry code alone. For this reason the bench sweeps every geometry code at the exact boundary addresses, as well as at random addresses. A teletext mapping that leaks row or geometry inputs shows as an address that changes while the low character bits are held fixed.

// File: rtl/vaw_pkg.sv
package vaw_pkg;

    typedef enum logic [1:0] {
        GEOM_20K = 2'd0,
        GEOM_16K = 2'd1,
        GEOM_10K = 2'd2,
        GEOM_8K  = 2'd3
    } geom_e;

    // Region size in units of one high-bit step (2K bytes by default).
    function automatic int geom_units(input geom_e g);
        int u;
        unique case (g)
            GEOM_20K: u = 10;
            GEOM_16K: u = 8;
            GEOM_10K: u = 5;
            GEOM_8K:  u = 4;
            default:  u = 10;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/vaw_fold_const.sv
module vaw_fold_const
    import vaw_pkg::*;
#(
    parameter int HI_W = 4
) (
    input  logic [1:0]      geom_sel,
    output logic [HI_W-1:0] fold_k
);
    localparam int MODV = 1 << HI_W;

    geom_e geom;
    int    units;

    always_comb begin
        geom   = geom_e'(geom_sel);
        units  = geom_units(geom);
        fold_k = HI_W'((MODV - units) % MODV);
    end

    // R3: constant plus region units is a whole multiple of the high-bit span
    always_comb begin
        assert_fold_const_R3: assert (((int'(fold_k) + units) % MODV) == 0)
            else $error("fold constant mismatch for geometry %0d", geom_sel);
    end

endmodule

// File: rtl/vaw_hi_adder.sv
module vaw_hi_adder #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    logic [W-1:0] cin;

    assign cin[0] = 1'b0;

    for (genvar g = 0; g < W; g++) begin : g_bit
        assign sum[g] = a[g] ^ b[g] ^ cin[g];
        if (g < W - 1) begin : g_carry
            assign cin[g+1] = (a[g] & b[g]) | (cin[g] & (a[g] ^ b[g]));
        end
    end

    // R2: ripple chain matches modular addition of the high field
    always_comb begin
        assert_hi_sum_R2: assert (sum == W'(a + b))
            else $error("high-field adder result wrong");
    end

endmodule

// File: rtl/vaw_bitmap_map.sv
module vaw_bitmap_map
    import vaw_pkg::*;
#(
    parameter int MA_W   = 14,
    parameter int RA_W   = 3,
    parameter int RAM_AW = 15,
    parameter int HI_W   = 4
) (
    input  logic [MA_W-2:0]   ma_lin,
    input  logic [RA_W-1:0]   row_line,
    input  logic [1:0]        geom_sel,
    output logic [RAM_AW-1:0] addr
);
    localparam int LIN_W  = MA_W - 1 + RA_W;
    localparam int HI_LSB = RAM_AW - HI_W;
    localparam int TOP    = 1 << RAM_AW;

    logic [LIN_W-1:0] lin;
    logic             over;
    logic [HI_W-1:0]  fold_k;
    logic [HI_W-1:0]  add_k;
    logic [HI_W-1:0]  hi_sum;

    assign lin   = {ma_lin, row_line};
    assign over  = lin[RAM_AW];
    assign add_k = over ? fold_k : '0;

    vaw_fold_const #(.HI_W(HI_W)) u_const (
        .geom_sel (geom_sel),
        .fold_k   (fold_k)
    );

    vaw_hi_adder #(.W(HI_W)) u_add (
        .a   (lin[RAM_AW-1 -: HI_W]),
        .b   (add_k),
        .sum (hi_sum)
    );

    assign addr = {hi_sum, lin[HI_LSB-1:0]};

    int size_b;
    always_comb size_b = geom_units(geom_e'(geom_sel)) << HI_LSB;

    always_comb begin
        // R1: below the RAM top the linear address passes untouched
        if (!over) begin
            assert_no_fold_R1: assert (addr == lin[RAM_AW-1:0])
                else $error("unfolded address altered");
        end
        // R2: folding never touches the bits below the high field
        assert_low_kept_R2: assert (addr[HI_LSB-1:0] == lin[HI_LSB-1:0])
            else $error("low address bits altered");
        // R6: a fold of an address just past the top lands inside the region
        if (over && (int'(lin) < TOP + size_b)) begin
            assert_in_region_R6: assert ((int'(addr) >= TOP - size_b) && (int'(addr) < TOP))
                else $error("folded address outside display region");
        end
    end

endmodule

// File: rtl/vaw_ttx_map.sv
module vaw_ttx_map #(
    parameter int RAM_AW = 15,
    parameter int TTX_AW = 10
) (
    input  logic [TTX_AW-1:0] ma_low,
    output logic [RAM_AW-1:0] addr
);
    assign addr = {{(RAM_AW - TTX_AW){1'b1}}, ma_low};
endmodule

// File: rtl/vid_addr_wrap.sv
module vid_addr_wrap #(
    parameter int MA_W   = 14,
    parameter int RA_W   = 3,
    parameter int RAM_AW = 15,
    parameter int HI_W   = 4,
    parameter int TTX_AW = 10
) (
    input  logic [MA_W-1:0]   char_addr,
    input  logic [1:0]        geom_sel,
    input  logic [RA_W-1:0]   row_line,
    output logic [RAM_AW-1:0] ram_addr
);
    localparam int WIN_W = RAM_AW - TTX_AW;

    logic              ttx_on;
    logic [RAM_AW-1:0] bm_addr;
    logic [RAM_AW-1:0] tx_addr;

    assign ttx_on = char_addr[MA_W-1];

    vaw_bitmap_map #(
        .MA_W   (MA_W),
        .RA_W   (RA_W),
        .RAM_AW (RAM_AW),
        .HI_W   (HI_W)
    ) u_bitmap (
        .ma_lin   (char_addr[MA_W-2:0]),
        .row_line (row_line),
        .geom_sel (geom_sel),
        .addr     (bm_addr)
    );

    vaw_ttx_map #(
        .RAM_AW (RAM_AW),
        .TTX_AW (TTX_AW)
    ) u_ttx (
        .ma_low (char_addr[TTX_AW-1:0]),
        .addr   (tx_addr)
    );

    always_comb begin
        unique case (ttx_on)
            1'b1:    ram_addr = tx_addr;
            default: ram_addr = bm_addr;
        endcase
    end

    always_comb begin
        // R4: teletext layout stays in the top window of RAM
        if (ttx_on) begin
            assert_ttx_window_R4: assert ((ram_addr[RAM_AW-1 -: WIN_W] == {WIN_W{1'b1}})
                                          && (ram_addr[TTX_AW-1:0] == char_addr[TTX_AW-1:0]))
                else $error("teletext address outside top window");
        end
    end

endmodule

// File: tb/test_vid_addr_wrap.sv
module test_vid_addr_wrap;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] char_addr = '0;
    logic [1:0]  geom_sel = '0;
    logic [2:0]  row_line = '0;
    logic [14:0] ram_addr;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    vid_addr_wrap i_vid_addr_wrap (
        .char_addr (char_addr),
        .geom_sel  (geom_sel),
        .row_line  (row_line),
        .ram_addr  (ram_addr)
    );

    // Behavioural reference: region size in bytes per geometry code (R3)
    function automatic int size_of(input int g);
        case (g)
            0: return 20 * 1024;
            1: return 16 * 1024;
            2: return 10 * 1024;
            default: return 8 * 1024;
        endcase
    endfunction

    function automatic int expect_addr(input int ma, input int g, input int row);
        int lin;
        if (ma >= 8192) return 31744 + (ma % 1024);
        lin = (ma % 8192) * 8 + row;
        if (lin >= 32768) lin = lin - size_of(g);
        return lin % 32768;
    endfunction

    // Compare on every clock, away from the driving edge (R7: same-cycle result)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int exp_v;
            exp_v = expect_addr(int'(char_addr), int'(geom_sel), int'(row_line));
            checks++;
            if (int'(ram_addr) != exp_v) begin
                errors++;
                $display("FAIL %s ma=%h geom=%0d row=%0d got=%h exp=%h",
                         cur_req, char_addr, geom_sel, row_line, ram_addr, exp_v);
            end
        end
    end

    task automatic apply(input int ma, input int g, input int row, input string req);
        @(posedge clk);
        char_addr = 14'(ma);
        geom_sel  = 2'(g);
        row_line  = 3'(row);
        cur_req   = req;
    endtask

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int sz;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset state: zero inputs give address zero (R1)
        apply(0, 0, 0, "R1_reset");
        // R1: unfolded bitmap addresses
        for (int g = 0; g < 4; g++) begin
            apply(16'h0123, g, 5, "R1");
            apply(16'h0FFF, g, 6, "R1");
            apply(16'h0800, g, 0, "R1");
        end
        // R2 and R3: first folded byte for each geometry code
        for (int g = 0; g < 4; g++) begin
            apply(16'h1000, g, 0, "R3");
            apply(16'h1234, g, 3, "R2");
            apply(16'h1FFF, g, 7, "R2");
        end
        // R8: step across the boundary; R6: last byte that wraps into the region
        for (int g = 0; g < 4; g++) begin
            sz = size_of(g);
            apply(16'h0FFF, g, 7, "R8");
            apply(16'h1000, g, 0, "R8");
            apply(16'h1000 + sz / 8 - 1, g, 7, "R6");
            apply(16'h1000 + sz / 16, g, 4, "R6");
        end
        // R4: teletext window
        apply(16'h2000, 0, 0, "R4");
        apply(16'h23FF, 1, 2, "R4");
        apply(16'h2155, 3, 7, "R4");
        // R5: teletext ignores rows, geometry and middle bits
        for (int k = 0; k < 32; k++) begin
            apply(16'h2000 | ((k % 8) << 10) | 10'h2A5, k % 4, (k * 3) % 8, "R5");
        end
        // R7: random inputs compared in the same cycle
        for (int n = 0; n < 3000; n++) begin
            apply(int'($urandom % 16384), int'($urandom % 4), int'($urandom % 8), "R7");
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule